// File: doc/BRIEF.md
# Serial Character Receiver with Threshold Interrupt

This block recovers 8-bit characters from one asynchronous serial line. A baud enable that pulses sixteen times per bit period sets the bit timing. A high-to-low transition seen while the receiver is idle opens a character. The line is checked again at the middle of the start bit, and a start bit that has gone high again by then is discarded as noise. Data bits arrive least significant first and are sampled at bit centres. Each finished character goes into a 64-entry receive queue, together with a flag that records a bad stop bit.

Software drains the queue through a read strobe. The head entry is always visible on the read data port before the strobe is given. A two-bit field picks a fill threshold. With the interrupt enabled, the interrupt request stays high while the fill level is at or above that threshold. When the queue is full, characters that complete are thrown away and a sticky overrun flag is raised. A clear strobe resets that flag.

Top module: `uart_rx_trigger`

## Requirements
- R1: While the receiver is idle and the serial line stays high, nothing is stored and the fill level does not change.
- R2: A falling edge seen on a baud tick opens a start check. The line is sampled again 8 baud ticks later. If it reads 1 at that point, the receiver returns to idle and stores nothing.
- R3: After a valid start, 8 data bits are sampled every 16 baud ticks, least significant bit first. The byte is presented on `rdData` in arrival order.
- R4: The stop bit is sampled 16 baud ticks after the last data bit. A 0 there stores the byte with `rdFrameErr` = 1. A 1 there stores it with `rdFrameErr` = 0.
- R5: The queue holds 64 entries and is first-word-fall-through: `rdData` and `rdFrameErr` show the oldest entry. A read strobe removes that entry at the next clock. A read strobe given while the queue is empty has no effect.
- R6: `rxRdy` is 1 exactly when the fill level is nonzero.
- R7: `trigSel` encodes the threshold: 0 gives 1 entry, 1 gives 16, 2 gives 32, 3 gives 56.
- R8: `irq` is 1 exactly when `intEn` is 1 and the fill level is at or above the selected threshold. It falls as soon as a read brings the level below the threshold.
- R9: Once 64 entries are held, further characters are discarded and the fill level stays 64.
- R10: A character that completes while the queue is full sets `overrun`. The flag stays set until a `clrOvr` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R11: After reset the queue is empty, and `rxRdy`, `irq` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudEn | input | 1 | One-cycle pulse at sixteen times the bit rate |
| serialIn | input | 1 | Serial line, idle high |
| rdStrobe | input | 1 | Removes the head entry |
| clrOvr | input | 1 | Clears the overrun flag |
| trigSel | input | 2 | Threshold select |
| intEn | input | 1 | Interrupt enable |
| rdData | output | 8 | Head entry byte |
| rdFrameErr | output | 1 | Head entry stop-bit error flag |
| fillLevel | output | 7 | Number of stored entries |
| rxRdy | output | 1 | Queue not empty |
| irq | output | 1 | Threshold interrupt request |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A bad bit counter or sample offset corrupts the byte of the very next character. That shows up on `rdData` one clock after the stop-bit centre, so each character is compared against a queue of expected values as soon as it is read. Faulty queue pointers or a faulty level counter appear within one read or write: the fill level steps by the wrong amount, or the head entry comes out of order. Threshold and overrun faults are exposed right at the character that crosses the boundary: the 1st, 16th, 56th and 65th stored or discarded character, and the first read after each of them.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

  // strobes from bit-timing control to the datapath
  typedef struct packed {
    logic shiftBit;  // sample line into shift register
    logic pushChar;  // character complete
    logic frameErr;  // stop bit read as 0
  } rxStrobe_t;

endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudEn,
  input  logic      serialIn,
  output rxStrobe_t strobes
);

  localparam int CW       = $clog2(OVERSAMPLE);
  localparam int BW       = $clog2(DATA_BITS + 1);
  localparam int HALF     = OVERSAMPLE / 2;
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OVERSAMPLE - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_BITS - 1);

  rxState_t        state;
  logic [CW-1:0]   tickCnt;
  logic [BW-1:0]   bitCnt;
  logic            lineQ;   // line value on previous baud tick

  logic atHalf;
  logic atFull;

  assign atHalf = (tickCnt == HALF_LAST);
  assign atFull = (tickCnt == FULL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      lineQ   <= 1'b1;
    end else if (baudEn) begin
      lineQ <= serialIn;
      unique case (state)
        RX_IDLE: begin
          if (lineQ && !serialIn) begin
            state   <= RX_START;
            tickCnt <= '0;
          end
        end
        RX_START: begin
          if (atHalf) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= serialIn ? RX_IDLE : RX_DATA;
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        RX_DATA: begin
          if (atFull) begin
            tickCnt <= '0;
            bitCnt  <= bitCnt + BW'(1);
            if (bitCnt == BIT_LAST) state <= RX_STOP;
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        RX_STOP: begin
          if (atFull) begin
            tickCnt <= '0;
            state   <= RX_IDLE;
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.shiftBit = baudEn && (state == RX_DATA) && atFull;
    strobes.pushChar = baudEn && (state == RX_STOP) && atFull;
    strobes.frameErr = !serialIn;
  end

endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int DEPTH     = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    serialIn,
  input  rxStrobe_t               strobes,
  input  logic                    rdStrobe,
  input  logic                    clrOvr,
  input  logic [1:0]              trigSel,
  input  logic                    intEn,
  output logic [DATA_BITS-1:0]    rdData,
  output logic                    rdFrameErr,
  output logic [$clog2(DEPTH):0]  fillLevel,
  output logic                    rxRdy,
  output logic                    irq,
  output logic                    overrun
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int EW = DATA_BITS + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_BITS-1:0] shiftReg;
  logic [EW-1:0]        mem [DEPTH];
  logic [AW-1:0]        wrPtr;
  logic [AW-1:0]        rdPtr;
  logic [CW-1:0]        count;
  logic                 ovrQ;
  logic [CW-1:0]        trigLevel;

  logic full, empty, doPush, doPop;

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign doPush = strobes.pushChar && !full;
  assign doPop  = rdStrobe && !empty;

  // LSB arrives first, so shift toward bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.shiftBit) shiftReg <= {serialIn, shiftReg[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {strobes.frameErr, shiftReg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop)  rdPtr <= rdPtr + AW'(1);
      unique case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // sticky overrun; a discard in the same cycle beats the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovrQ <= 1'b0;
    else if (strobes.pushChar && full) ovrQ <= 1'b1;
    else if (clrOvr) ovrQ <= 1'b0;
  end

  always_comb begin
    unique case (trigSel)
      2'd0:    trigLevel = CW'(1);
      2'd1:    trigLevel = CW'(DEPTH / 4);
      2'd2:    trigLevel = CW'(DEPTH / 2);
      default: trigLevel = CW'(DEPTH - 8);
    endcase
  end

  assign rdData     = mem[rdPtr][DATA_BITS-1:0];
  assign rdFrameErr = mem[rdPtr][DATA_BITS];
  assign fillLevel  = count;
  assign rxRdy      = !empty;
  assign irq        = intEn && (count >= trigLevel);
  assign overrun    = ovrQ;

endmodule

// File: rtl/uart_rx_trigger.sv
module uart_rx_trigger
  import srx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16,
  parameter int DEPTH      = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    baudEn,
  input  logic                    serialIn,
  input  logic                    rdStrobe,
  input  logic                    clrOvr,
  input  logic [1:0]              trigSel,
  input  logic                    intEn,
  output logic [DATA_BITS-1:0]    rdData,
  output logic                    rdFrameErr,
  output logic [$clog2(DEPTH):0]  fillLevel,
  output logic                    rxRdy,
  output logic                    irq,
  output logic                    overrun
);

  rxStrobe_t strobes;
  logic      charPush;

  assign charPush = strobes.pushChar;

  srx_ctrl #(
    .DATA_BITS (DATA_BITS),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .baudEn  (baudEn),
    .serialIn(serialIn),
    .strobes (strobes)
  );

  srx_datapath #(
    .DATA_BITS(DATA_BITS),
    .DEPTH    (DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .strobes   (strobes),
    .rdStrobe  (rdStrobe),
    .clrOvr    (clrOvr),
    .trigSel   (trigSel),
    .intEn     (intEn),
    .rdData    (rdData),
    .rdFrameErr(rdFrameErr),
    .fillLevel (fillLevel),
    .rxRdy     (rxRdy),
    .irq       (irq),
    .overrun   (overrun)
  );

endmodule

// File: rtl/uart_rx_trigger_chk.sv
module uart_rx_trigger_chk #(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   rdStrobe,
  input logic                   clrOvr,
  input logic                   intEn,
  input logic [$clog2(DEPTH):0] fillLevel,
  input logic                   rxRdy,
  input logic                   irq,
  input logic                   overrun,
  input logic                   charPush
);

  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // R9: level never exceeds capacity
  a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= FULL_CNT);

  // R5: level moves by at most one entry per clock
  a_r5_level_step: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == $past(fillLevel)) ||
    (fillLevel == $past(fillLevel) + CW'(1)) ||
    (fillLevel == $past(fillLevel) - CW'(1)));

  // R5: read of an empty queue changes nothing
  a_r5_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == '0 && rdStrobe && !charPush) |=> (fillLevel == '0));

  // R6: a push into an empty queue raises ready
  a_r6_ready_after_push: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == '0 && charPush) |=> rxRdy);

  // R9: full queue stays full without a read
  a_r9_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == FULL_CNT && !rdStrobe) |=> (fillLevel == FULL_CNT));

  // R10: completion while full raises overrun
  a_r10_set_on_full: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == FULL_CNT && charPush) |=> overrun);

  // R10: overrun is sticky until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrOvr) |=> overrun);

  // R10: clear works unless a discard coincides
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrOvr && !(charPush && fillLevel == FULL_CNT)) |=> !overrun);

  // R8: no request while disabled
  a_r8_masked: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |-> !irq);

endmodule

bind uart_rx_trigger uart_rx_trigger_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdStrobe (rdStrobe),
  .clrOvr   (clrOvr),
  .intEn    (intEn),
  .fillLevel(fillLevel),
  .rxRdy    (rxRdy),
  .irq      (irq),
  .overrun  (overrun),
  .charPush (charPush)
);

// File: tb/test_uart_rx_trigger.sv
`timescale 1ns/100ps
module test_uart_rx_trigger;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudEn = 1'b0;
  logic       serialIn = 1'b1;
  logic       rdStrobe = 1'b0;
  logic       clrOvr = 1'b0;
  logic [1:0] trigSel = 2'd0;
  logic       intEn = 1'b0;
  logic [7:0] rdData;
  logic       rdFrameErr;
  logic [6:0] fillLevel;
  logic       rxRdy;
  logic       irq;
  logic       overrun;

  int checks = 0;
  int errors = 0;
  int popBudget = 0;
  bit forceRd = 1'b0;
  bit done = 1'b0;
  logic [8:0] expQ[$];

  uart_rx_trigger i_uart_rx_trigger (
    .clk(clk), .rstN(rstN), .baudEn(baudEn), .serialIn(serialIn),
    .rdStrobe(rdStrobe), .clrOvr(clrOvr), .trigSel(trigSel), .intEn(intEn),
    .rdData(rdData), .rdFrameErr(rdFrameErr), .fillLevel(fillLevel),
    .rxRdy(rxRdy), .irq(irq), .overrun(overrun)
  );

  always #2.5 clk = ~clk;

  // baud tick on every second rising edge
  always @(negedge clk) baudEn <= ~baudEn;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops entries and compares against the scoreboard
  always @(negedge clk) begin
    if (forceRd) begin
      rdStrobe = 1'b1;
    end else if (popBudget > 0 && rxRdy) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R5 unexpected entry", int'({rdFrameErr, rdData}), -1);
      end else begin
        logic [8:0] expV;
        expV = expQ.pop_front();
        chk({rdFrameErr, rdData} == expV, "R3 R4 entry content/order",
            int'({rdFrameErr, rdData}), int'(expV));
      end
      rdStrobe = 1'b1;
      popBudget--;
    end else begin
      rdStrobe = 1'b0;
    end
  end

  task automatic tick();
    do @(posedge clk); while (!baudEn);
    #1;
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // driver: serialises one character and records the expected entry
  task automatic sendChar(input logic [7:0] b, input bit stopOk, input bit stored);
    if (stored) expQ.push_back({~stopOk, b});
    tick();
    serialIn = 1'b0;
    waitTicks(16);
    for (int i = 0; i < 8; i++) begin
      serialIn = b[i];
      waitTicks(16);
    end
    serialIn = stopOk;
    waitTicks(16);
    serialIn = 1'b1;
    waitTicks(16);
  endtask

  task automatic popN(input int n);
    popBudget = n;
    while (popBudget > 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drainAll();
    popBudget = 1000;
    while (fillLevel != 0) @(negedge clk);
    @(negedge clk);
    popBudget = 0;
    @(negedge clk);
    chk(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(fillLevel == 0, "R11 fill after reset", fillLevel, 0);
    chk(rxRdy == 0, "R11 rxRdy after reset", rxRdy, 0);
    chk(irq == 0 && overrun == 0, "R11 irq/overrun after reset", {irq, overrun}, 0);
    rstN = 1'b1;

    // R1: idle high line stores nothing
    waitTicks(100);
    @(negedge clk);
    chk(fillLevel == 0, "R1 idle line", fillLevel, 0);

    // R2: short low pulses rejected at the start check
    tick(); serialIn = 1'b0; waitTicks(4); serialIn = 1'b1; waitTicks(200);
    @(negedge clk);
    chk(fillLevel == 0, "R2 4-tick glitch rejected", fillLevel, 0);
    tick(); serialIn = 1'b0; waitTicks(7); serialIn = 1'b1; waitTicks(200);
    @(negedge clk);
    chk(fillLevel == 0, "R2 7-tick glitch rejected", fillLevel, 0);

    // R5: read strobe on an empty queue ignored
    @(negedge clk); forceRd = 1'b1;
    @(negedge clk); forceRd = 1'b0;
    @(negedge clk);
    chk(fillLevel == 0 && rxRdy == 0, "R5 empty read ignored", fillLevel, 0);

    // R3 R4: streaming with the monitor draining
    popBudget = 1000;
    sendChar(8'h55, 1'b1, 1'b1);
    sendChar(8'hA3, 1'b1, 1'b1);
    sendChar(8'h01, 1'b1, 1'b1);
    sendChar(8'h80, 1'b1, 1'b1);
    sendChar(8'h3C, 1'b0, 1'b1);   // R4 framing error
    sendChar(8'hFF, 1'b1, 1'b1);
    waitTicks(4);
    popBudget = 0;
    @(negedge clk);
    chk(expQ.size() == 0 && fillLevel == 0, "R3 stream drained", expQ.size(), 0);

    // R7 R8: threshold 1
    intEn = 1'b1; trigSel = 2'd0;
    sendChar(8'h11, 1'b1, 1'b1);
    @(negedge clk);
    chk(fillLevel == 1 && rxRdy == 1, "R6 one entry ready", fillLevel, 1);
    chk(irq == 1, "R7 threshold 1 reached", irq, 1);
    popN(1);
    chk(irq == 0 && rxRdy == 0, "R8 irq falls below threshold", irq, 0);

    // R7 R8: threshold 16
    trigSel = 2'd1;
    for (int i = 0; i < 15; i++) sendChar(8'(i * 13 + 5), 1'b1, 1'b1);
    @(negedge clk);
    chk(irq == 0, "R7 level 15 below 16", irq, 0);
    sendChar(8'hC7, 1'b1, 1'b1);
    @(negedge clk);
    chk(irq == 1 && fillLevel == 16, "R7 level 16 reached", fillLevel, 16);
    intEn = 1'b0; @(negedge clk);
    chk(irq == 0, "R8 disabled masks irq", irq, 0);
    intEn = 1'b1; trigSel = 2'd2; @(negedge clk);
    chk(irq == 0, "R7 16 below threshold 32", irq, 0);
    trigSel = 2'd1;
    popN(1);
    chk(irq == 0 && fillLevel == 15, "R8 read drops below 16", fillLevel, 15);
    drainAll();

    // R7 R9 R10: threshold 56, fill and overrun
    trigSel = 2'd3;
    for (int i = 0; i < 55; i++) sendChar(8'(i * 7 + 3), 1'b1, 1'b1);
    @(negedge clk);
    chk(irq == 0 && fillLevel == 55, "R7 level 55 below 56", fillLevel, 55);
    sendChar(8'h9A, 1'b1, 1'b1);
    @(negedge clk);
    chk(irq == 1, "R7 level 56 reached", irq, 1);
    for (int i = 0; i < 8; i++) sendChar(8'(i + 200), 1'b1, 1'b1);
    @(negedge clk);
    chk(fillLevel == 64 && overrun == 0, "R9 full without overrun", fillLevel, 64);
    sendChar(8'hEE, 1'b1, 1'b0);
    @(negedge clk);
    chk(fillLevel == 64, "R9 extra char discarded", fillLevel, 64);
    chk(overrun == 1, "R10 overrun set", overrun, 1);
    waitTicks(50);
    @(negedge clk);
    chk(overrun == 1, "R10 overrun sticky", overrun, 1);
    clrOvr = 1'b1; @(negedge clk); clrOvr = 1'b0; @(negedge clk);
    chk(overrun == 0, "R10 overrun cleared", overrun, 0);
    drainAll();
    chk(rxRdy == 0 && irq == 0, "R6 empty after drain", rxRdy, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule